// File: doc/BRIEF.md
# Resonance Deviation Guard Controller

This block keeps a half-bridge resonant converter from drifting into the capacitive switching region. Two-flop synchronizers bring in comparator flags for the polarity of the winding voltage and for the resonant-current sense. The current is compared against four levels: an upper and a lower outer limit, and an upper and a lower margin limit. The block watches the rising edges of the high-side and low-side gates. For each side it raises a phase-detect flag when the winding polarity at turn-on shows that the tank current is already heading the wrong way.

A shared 4-bit thermometer code sets how long each side may stay on once its flag is up. The code moves one step up on a gate turn-on that finds the current short of its margin. It returns to zero when the current passes an outer limit on a side whose flag is quiet. Each side has a delay stage, modelled as a counter. Its length is a base count plus a fixed increment for each set bit of the code. The two stage outputs are ORed into one terminate signal, and that signal forces whichever gate is on to low. Repeated deviations therefore tighten the switching period step by step toward the minimum frequency. A clean cycle releases the guard.

Top module: `rdg_ctrl`

## Requirements
- R1: `pd_hi_o` goes high one cycle after a sampled `gate_hi_i` rising edge that finds the synchronized winding flag `vw_pos_i` low. It then stays high for as long as `gate_hi_i` is high. It is low in every cycle after `gate_hi_i` is sampled low.
- R2: `pd_lo_o` goes high one cycle after a sampled `gate_lo_i` rising edge that finds the synchronized `vw_pos_i` high. It then stays high for as long as `gate_lo_i` is high. It is low in every cycle after `gate_lo_i` is sampled low.
- R3: A `gate_hi_i` rising edge with a nonzero code and the synchronized `is_below_mlo_i` high advances the code. When the code is zero, or `is_below_mlo_i` is low, the edge leaves the code unchanged.
- R4: A `gate_lo_i` rising edge with the synchronized `is_below_mhi_i` high advances the code. To advance, the code shifts one place toward bit 3 and a 1 enters bit 0: 0000, 0001, 0011, 0111, 1111. The code is visible on `code_o` the cycle after the edge.
- R5: The code clears to 0000 the cycle after either of two conditions holds. One is `pd_hi_o` low while the synchronized `is_above_ohi_i` is high. The other is `pd_lo_o` low while the synchronized `is_below_olo_i` is high. A clear takes priority over an advance in the same cycle.
- R6: Further advance requests at 1111 leave the code at 1111.
- R7: The delay length is L = BASE_CNT + STEP_CNT × (number of ones in the code), which is 8 + 4·n by default. `term_o` goes high exactly L cycles after a phase-detect flag rises, for as long as that flag stays high. The two sides are ORed.
- R8: `drv_hi_o` equals `gate_hi_i` and `drv_lo_o` equals `gate_lo_i`, except that both are low while `term_o` is high.
- R9: A comparator input changed before clock edge k is first used at edge k+2. With the default of two synchronizer stages, its effect shows one cycle after that.
- R10: After synchronous active-low reset, the code, both flags, `term_o` and both drive outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_hi_i | input | 1 | High-side gate request |
| gate_lo_i | input | 1 | Low-side gate request |
| vw_pos_i | input | 1 | Winding voltage positive (async) |
| is_above_ohi_i | input | 1 | Current above upper outer limit (async) |
| is_below_olo_i | input | 1 | Current below lower outer limit (async) |
| is_below_mlo_i | input | 1 | Current below lower margin limit (async) |
| is_below_mhi_i | input | 1 | Current below upper margin limit (async) |
| pd_hi_o | output | 1 | High-side phase-detect flag |
| pd_lo_o | output | 1 | Low-side phase-detect flag |
| term_o | output | 1 | Merged early-terminate |
| drv_hi_o | output | 1 | High-side gate drive after guard |
| drv_lo_o | output | 1 | Low-side gate drive after guard |
| code_o | output | CODE_W | Thermometer delay code |

## Verification
A gate edge shows on the flags and on `code_o` one cycle after the edge at which it is sampled. Comparator inputs pass through the synchronizer, so they take effect two edges later and are visible one cycle after that. `term_o` follows a flag rise by exactly L cycles, while the drive outputs respond to the gate inputs within the same cycle. The bench drives inputs on the falling clock edge and keeps a cycle model that includes the synchronizer pipeline. It compares every output at the next falling edge. The directed cases then probe the cycles on either side of each deadline: the cycle before `term_o` rises and the cycle it rises, and the cycle before a clear lands and the cycle it lands.

// File: rtl/rdg_pkg.sv
package rdg_pkg;
   // bit positions inside the synchronized comparator bundle
   localparam int SYN_VW  = 0;
   localparam int SYN_OHI = 1;
   localparam int SYN_OLO = 2;
   localparam int SYN_MLO = 3;
   localparam int SYN_MHI = 4;
   localparam int SYN_W   = 5;

   function automatic int count_ones(input logic [15:0] v);
      int n;
      n = 0;
      for (int i = 0; i < 16; i++) n += int'(v[i]);
      return n;
   endfunction
endpackage

// File: rtl/rdg_sync.sv
module rdg_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rdg_code.sv
module rdg_code #(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic              clr_i,
   output logic [CODE_W-1:0] code_o
);
   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                         code_q <= '0;
      else if (clr_i)                     code_q <= '0;
      else if (adv_i && !code_q[CODE_W-1]) code_q <= {code_q[CODE_W-2:0], 1'b1};
   end

   assign code_o = code_q;

   // R4: thermometer form is kept at all times
   p_thermo_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(code_q + 1'b1));

   // R3: any change other than a clear adds exactly one set bit
   p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(code_q) && code_q != '0) |->
         ($countones(code_q) == $countones($past(code_q)) + 1));

   // R6: a full code never grows, it only holds or clears
   p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((&$past(code_q)) && code_q != '0) |-> (&code_q));
endmodule

// File: rtl/rdg_delay.sv
module rdg_delay #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flag_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             fire_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!flag_i)    cnt_q <= '0;
      else if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
   end

   assign fire_o = flag_i && (cnt_q >= len_i);

   // R7: the stage only fires after its flag has been held at least one cycle
   p_fire_after_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> $past(flag_i));
endmodule

// File: rtl/rdg_ctrl.sv
module rdg_ctrl
   import rdg_pkg::*;
#(
   parameter int CODE_W      = 4,
   parameter int BASE_CNT    = 8,
   parameter int STEP_CNT    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_hi_i,
   input  logic              gate_lo_i,
   input  logic              vw_pos_i,
   input  logic              is_above_ohi_i,
   input  logic              is_below_olo_i,
   input  logic              is_below_mlo_i,
   input  logic              is_below_mhi_i,
   output logic              pd_hi_o,
   output logic              pd_lo_o,
   output logic              term_o,
   output logic              drv_hi_o,
   output logic              drv_lo_o,
   output logic [CODE_W-1:0] code_o
);
   localparam int MAX_LEN = BASE_CNT + STEP_CNT * CODE_W;
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   generate
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_code_w
         $error("rdg_ctrl: CODE_W must lie in 2..16");
      end
      if (BASE_CNT < 1 || STEP_CNT < 0) begin : g_bad_delay
         $error("rdg_ctrl: BASE_CNT must be >= 1 and STEP_CNT >= 0");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rdg_ctrl: SYNC_STAGES must be >= 2");
      end
   endgenerate

   // comparator synchronization
   logic [SYN_W-1:0] raw_cmp, syn;
   always_comb begin
      raw_cmp          = '0;
      raw_cmp[SYN_VW]  = vw_pos_i;
      raw_cmp[SYN_OHI] = is_above_ohi_i;
      raw_cmp[SYN_OLO] = is_below_olo_i;
      raw_cmp[SYN_MLO] = is_below_mlo_i;
      raw_cmp[SYN_MHI] = is_below_mhi_i;
   end

   rdg_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_cmp), .q_o(syn)
   );

   // phase detectors
   logic gh_d, gl_d, pd_hi_q, pd_lo_q;
   logic rise_hi, rise_lo;
   assign rise_hi = gate_hi_i & ~gh_d;
   assign rise_lo = gate_lo_i & ~gl_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gh_d    <= 1'b0;
         gl_d    <= 1'b0;
         pd_hi_q <= 1'b0;
         pd_lo_q <= 1'b0;
      end else begin
         gh_d    <= gate_hi_i;
         gl_d    <= gate_lo_i;
         pd_hi_q <= gate_hi_i & (rise_hi ? ~syn[SYN_VW] : pd_hi_q);
         pd_lo_q <= gate_lo_i & (rise_lo ?  syn[SYN_VW] : pd_lo_q);
      end
   end

   // shared thermometer code
   logic              adv, clr;
   logic [CODE_W-1:0] code_q;
   assign adv = (rise_hi & (|code_q) & syn[SYN_MLO]) | (rise_lo & syn[SYN_MHI]);
   assign clr = (~pd_hi_q & syn[SYN_OHI]) | (~pd_lo_q & syn[SYN_OLO]);

   rdg_code #(.CODE_W(CODE_W)) u_code (
      .clk(clk), .rst_n(rst_n), .adv_i(adv), .clr_i(clr), .code_o(code_q)
   );

   // delay stages, one per side, sharing the length
   logic [CNT_W-1:0] dly_len;
   assign dly_len = CNT_W'(BASE_CNT + STEP_CNT * count_ones(16'(code_q)));

   logic [1:0] pd_v, fire_v;
   assign pd_v = {pd_lo_q, pd_hi_q};

   for (genvar s = 0; s < 2; s++) begin : g_side
      rdg_delay #(.CNT_W(CNT_W)) u_dly (
         .clk(clk), .rst_n(rst_n), .flag_i(pd_v[s]), .len_i(dly_len), .fire_o(fire_v[s])
      );
   end

   assign term_o   = |fire_v;
   assign drv_hi_o = gate_hi_i & ~term_o;
   assign drv_lo_o = gate_lo_i & ~term_o;
   assign pd_hi_o  = pd_hi_q;
   assign pd_lo_o  = pd_lo_q;
   assign code_o   = code_q;

   // R1: high flag only while the high gate was on at the previous edge
   p_pd_hi_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pd_hi_q |-> $past(gate_hi_i));

   // R2: low flag only while the low gate was on at the previous edge
   p_pd_lo_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pd_lo_q |-> $past(gate_lo_i));

   // R5: a qualifying outer crossing leaves the code at zero one edge later
   p_clear_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (code_q == '0));
endmodule

// File: tb/rdg_ctrl_tb.sv
module rdg_ctrl_tb;
   localparam int BASE = 8;
   localparam int STEP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gh = 0, gl = 0, vw = 0, ohi = 0, olo = 0, mlo = 0, mhi = 0;
   logic pd_hi, pd_lo, term, drv_hi, drv_lo;
   logic [3:0] code;

   always #10 clk = ~clk;

   rdg_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .gate_hi_i(gh), .gate_lo_i(gl), .vw_pos_i(vw),
      .is_above_ohi_i(ohi), .is_below_olo_i(olo), .is_below_mlo_i(mlo),
      .is_below_mhi_i(mhi), .pd_hi_o(pd_hi), .pd_lo_o(pd_lo), .term_o(term),
      .drv_hi_o(drv_hi), .drv_lo_o(drv_lo), .code_o(code)
   );

   int n_chk = 0, n_fail = 0;

   // reference model state
   logic [4:0] m_s1, m_s2;
   logic       m_ghd, m_gld, m_pdh, m_pdl;
   logic [3:0] m_code;
   int         m_cnth, m_cntl;

   function automatic int ones(input logic [3:0] v);
      return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
   endfunction

   function automatic int exp_len(input logic [3:0] c);
      return BASE + STEP * ones(c);
   endfunction

   function automatic logic exp_term();
      return (m_pdh && m_cnth >= exp_len(m_code)) || (m_pdl && m_cntl >= exp_len(m_code));
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_s1 = '0; m_s2 = '0; m_ghd = 0; m_gld = 0; m_pdh = 0; m_pdl = 0;
      m_code = '0; m_cnth = 0; m_cntl = 0;
   endtask

   task automatic model_step();
      logic rh, rl, clr, adv;
      logic [3:0] nc;
      rh  = gh & ~m_ghd;
      rl  = gl & ~m_gld;
      clr = (~m_pdh & m_s2[1]) | (~m_pdl & m_s2[2]);
      adv = (rh & (m_code != 0) & m_s2[3]) | (rl & m_s2[4]);
      nc  = clr ? 4'b0000 : (adv ? {m_code[2:0], 1'b1} : m_code);
      m_cnth = m_pdh ? ((m_cnth < 1000) ? m_cnth + 1 : m_cnth) : 0;
      m_cntl = m_pdl ? ((m_cntl < 1000) ? m_cntl + 1 : m_cntl) : 0;
      m_pdh  = gh & (rh ? ~m_s2[0] : m_pdh);
      m_pdl  = gl & (rl ?  m_s2[0] : m_pdl);
      m_code = nc;
      m_s2   = m_s1;
      m_s1   = {mhi, mlo, olo, ohi, vw};
      m_ghd  = gh;
      m_gld  = gl;
   endtask

   task automatic model_check();
      logic t;
      t = exp_term();
      chk("pd_hi R1", int'(pd_hi), int'(m_pdh));
      chk("pd_lo R2", int'(pd_lo), int'(m_pdl));
      chk("code R3,R4,R5,R6,R9", int'(code), int'(m_code));
      chk("term R7", int'(term), int'(t));
      chk("drv_hi R8", int'(drv_hi), int'(gh & ~t));
      chk("drv_lo R8", int'(drv_lo), int'(gl & ~t));
   endtask

   // one clock: inputs already set, update model at edge, compare at falling edge
   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      model_check();
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("reset code R10", int'(code), 0);
      chk("reset pd R10", int'(pd_hi | pd_lo), 0);
      chk("reset term R10", int'(term), 0);
      chk("reset drv R10", int'(drv_hi | drv_lo), 0);

      // R4, R2: low turn-on short of the upper margin starts the code
      vw = 1; mhi = 1;
      ticks(3);
      gl = 1;
      tick();
      chk("first advance R4", int'(code), 4'b0001);
      chk("low flag R2", int'(pd_lo), 1);

      // R7, R8: terminate exactly 12 cycles after the flag rise
      ticks(11);
      chk("term not yet R7", int'(term), 0);
      tick();
      chk("term due R7", int'(term), 1);
      chk("drive forced low R8", int'(drv_lo), 0);

      // R3, R1: high turn-on with negative winding and current below margin
      gl = 0; tick();
      vw = 0; mlo = 1;
      ticks(3);
      gh = 1; tick();
      chk("second advance R3", int'(code), 4'b0011);
      chk("high flag R1", int'(pd_hi), 1);

      // R6: saturation
      gh = 0; tick(); gh = 1; tick();
      chk("third advance R4", int'(code), 4'b0111);
      gh = 0; tick(); gh = 1; tick();
      chk("full code R6", int'(code), 4'b1111);
      gh = 0; tick(); gh = 1; tick();
      chk("saturated R6", int'(code), 4'b1111);

      // R9, R5: outer crossing clears after synchronizer latency
      gh = 0; tick();
      ohi = 1;
      ticks(2);
      chk("clear not yet R9", int'(code), 4'b1111);
      tick();
      chk("cleared R5", int'(code), 4'b0000);
      ohi = 0;
      ticks(3);

      // R3: high edge with zero code does not advance
      gh = 1; tick();
      chk("no advance at zero R3", int'(code), 4'b0000);
      gh = 0; tick();

      // random half-bridge cycling
      for (int cyc = 0; cyc < 400; cyc++) begin
         int on_len;
         for (int side = 0; side < 2; side++) begin
            on_len = 4 + int'($urandom_range(0, 30));
            if (side == 0) gh = 1; else gl = 1;
            for (int k = 0; k < on_len; k++) begin
               vw  = 1'($urandom_range(0, 1));
               mlo = ($urandom_range(0, 3) != 0);
               mhi = ($urandom_range(0, 3) != 0);
               ohi = ($urandom_range(0, 15) == 0);
               olo = ($urandom_range(0, 15) == 0);
               tick();
            end
            gh = 0; gl = 0;
            ticks(1 + int'($urandom_range(0, 2)));
         end
      end

      finish_run();
   end
endmodule